// File: doc/BRIEF.md
# Two-Requester Alternating-Turn Bus Arbiter

This block decides which of two bus masters may drive a shared bus. A master raises its request line and keeps it raised for the whole of its transfer. The arbiter answers with a grant line for that master. It never takes the bus away from an owner whose request is still high.

When the owner lowers its request, the arbiter looks at the other master in the same clock edge. If the other master is waiting, the bus passes straight to it with no idle cycle between. If nobody is waiting, the bus goes idle. The arbiter then remembers that the master which just finished has had its turn. The next simultaneous request is won by the other master, however long the idle period lasts.

The design is a four-state machine. There are two ownership states, and two idle states that differ only in whose turn comes next. The grant lines come from their own flip-flops, loaded from the decoded next state, so they change only on a rising clock edge.

Top module: `rr2_bus_arbiter`

## Requirements
- R1: While reset is low both grants are low; after reset the idle turn belongs to requester 0, so a first simultaneous request is granted to requester 0.
- R2: gnt0 and gnt1 are never high in the same cycle.
- R3: Once a requester owns the bus, it keeps its grant on every edge at which its own request is still high; the other request line has no effect on either grant during that time.
- R4: On the first edge at which the owner's request is seen low while the other request is high, the grant moves to the other requester at that same edge, with no cycle of both grants low.
- R5: On the first edge at which the owner's request is seen low while the other request is also low, both grants go low and the turn passes to the requester that did not just own the bus.
- R6: When the bus is idle and both requests are seen high at one edge, the grant goes to the requester whose turn it is.
- R7: When the bus is idle and exactly one request is seen high, that requester is granted at that edge, whatever the turn.
- R8: The turn is kept unchanged through any number of idle cycles with both requests low.
- R9: Grants are registered: they change only at a rising clock edge, and a grant is high only if its request was high at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req0 | input | 1 | Bus request from requester 0 |
| req1 | input | 1 | Bus request from requester 1 |
| gnt0 | output | 1 | Bus grant to requester 0, registered |
| gnt1 | output | 1 | Bus grant to requester 1, registered |

## Verification
Some properties are checked on every cycle by the assertions. These are mutual exclusion of the grants, that a granted request was really present, ownership holding while the request stays high, the same-edge hand-off, release to idle with the turn passed on, the single-request grant, and the turn-based choice on a conflict. Other behaviour can only be shown by the bench's directed scenarios. One case is that the turn survives idle periods of several lengths. Another is that a request edge between clock edges leaves the grants alone until the next rising edge. A third is that the full sequence after reset gives the expected grant pattern at every step.

// File: rtl/rr2_arb_pkg.sv
package rr2_arb_pkg;

  localparam int unsigned NUM_REQ = 2;
  localparam int unsigned ST_W    = 2;

  // Bit 1 marks ownership, bit 0 names the device (owner, or next in turn).
  typedef enum logic [ST_W-1:0] {
    ST_IDLE_TURN0 = 2'b00,
    ST_IDLE_TURN1 = 2'b01,
    ST_OWN0       = 2'b10,
    ST_OWN1       = 2'b11
  } arb_state_e;

  localparam arb_state_e RESET_STATE = ST_IDLE_TURN0;

  function automatic logic is_owned(input arb_state_e s);
    return s[1];
  endfunction

  function automatic logic state_dev(input arb_state_e s);
    return s[0];
  endfunction

  function automatic arb_state_e own_state(input logic dev);
    return dev ? ST_OWN1 : ST_OWN0;
  endfunction

  function automatic arb_state_e idle_state(input logic turn);
    return turn ? ST_IDLE_TURN1 : ST_IDLE_TURN0;
  endfunction

  // Next state from current state and the request pair {req1, req0}.
  function automatic arb_state_e next_state(input arb_state_e s,
                                            input logic [NUM_REQ-1:0] req);
    logic dev;
    logic other;
    dev   = state_dev(s);
    other = ~dev;
    if (is_owned(s)) begin
      if (req[dev])        return s;
      else if (req[other]) return own_state(other);
      else                 return idle_state(other);
    end else begin
      if (req[dev])        return own_state(dev);
      else if (req[other]) return own_state(other);
      else                 return s;
    end
  endfunction

  // One-hot grant vector for a state; idle states grant nobody.
  function automatic logic [NUM_REQ-1:0] grant_of(input arb_state_e s);
    logic [NUM_REQ-1:0] g;
    g = '0;
    if (is_owned(s)) g[state_dev(s)] = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/rr2_arb_next.sv
module rr2_arb_next
  import rr2_arb_pkg::*;
(
  input  arb_state_e         state_q,
  input  logic [NUM_REQ-1:0] req,
  output arb_state_e         state_d,
  output logic               ev_release,
  output logic               ev_handoff,
  output logic               ev_conflict
);

  logic owner;
  logic owned;

  always_comb begin
    owned   = is_owned(state_q);
    owner   = state_dev(state_q);
    state_d = next_state(state_q, req);
  end

  // Named events for the checks in the top module.
  always_comb begin
    ev_release  = owned && !req[owner];
    ev_handoff  = ev_release && req[~owner];
    ev_conflict = !owned && (&req);
  end

endmodule

// File: rtl/rr2_arb_state_reg.sv
module rr2_arb_state_reg
  import rr2_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_e state_d,
  output arb_state_e state_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_STATE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/rr2_arb_grant_reg.sv
module rr2_arb_grant_reg
  import rr2_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  arb_state_e         state_d,
  output logic [NUM_REQ-1:0] gnt_q
);

  logic [NUM_REQ-1:0] gnt_d;

  always_comb gnt_d = grant_of(state_d);

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gnt_q[i] <= 1'b0;
        else        gnt_q[i] <= gnt_d[i];
      end
    end
  endgenerate

  // R2: the two grant flops never hold 1 together
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_q) <= 1);

endmodule

// File: rtl/rr2_bus_arbiter.sv
module rr2_bus_arbiter
  import rr2_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  output logic gnt0,
  output logic gnt1
);

  logic [NUM_REQ-1:0] req;
  logic [NUM_REQ-1:0] gnt;
  arb_state_e         state_q;
  arb_state_e         state_d;
  logic               ev_release;
  logic               ev_handoff;
  logic               ev_conflict;

  assign req  = {req1, req0};
  assign gnt0 = gnt[0];
  assign gnt1 = gnt[1];

  rr2_arb_next u_next (
    .state_q    (state_q),
    .req        (req),
    .state_d    (state_d),
    .ev_release (ev_release),
    .ev_handoff (ev_handoff),
    .ev_conflict(ev_conflict)
  );

  rr2_arb_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_d(state_d),
    .state_q(state_q)
  );

  rr2_arb_grant_reg u_gnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_d(state_d),
    .gnt_q  (gnt)
  );

  // R3: owner with request still high keeps the bus
  p_hold0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0 && req0) |=> (gnt0 && !gnt1));
  p_hold1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt1 && req1) |=> (gnt1 && !gnt0));

  // R4: release with the other side waiting hands over at once
  p_handoff0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0 && !req0 && req1) |=> gnt1);
  p_handoff1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt1 && !req1 && req0) |=> gnt0);
  p_handoff_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handoff |=> (gnt0 != $past(gnt0)) && (gnt1 != $past(gnt1)));

  // R5: release with nobody waiting idles the bus and passes the turn
  p_release0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0 && !req0 && !req1) |=> (!gnt0 && !gnt1 && state_q == ST_IDLE_TURN1));
  p_release1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt1 && !req1 && !req0) |=> (!gnt0 && !gnt1 && state_q == ST_IDLE_TURN0));

  // R6: idle conflict resolved by the stored turn
  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_conflict |=> (state_dev($past(state_q)) ? gnt1 : gnt0));

  // R7: a lone request on an idle bus wins
  p_single0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt0 && !gnt1 && req0 && !req1) |=> gnt0);
  p_single1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt0 && !gnt1 && req1 && !req0) |=> gnt1);

  // R8: idle with no requests keeps the turn
  p_turn_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_owned(state_q) && !req0 && !req1) |=> $stable(state_q));

  // R9: a grant only follows a request seen at the producing edge
  p_gnt_req0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt0) |-> $past(req0));
  p_gnt_req1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt1) |-> $past(req1));

endmodule

// File: tb/sim_rr2_bus_arbiter.sv
`timescale 1ns/1ps
module sim_rr2_bus_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req0 = 1'b0;
  logic req1 = 1'b0;
  logic gnt0;
  logic gnt1;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  rr2_bus_arbiter u0 (
    .clk  (clk),
    .rst_n(rst_n),
    .req0 (req0),
    .req1 (req1),
    .gnt0 (gnt0),
    .gnt1 (gnt1)
  );

  task automatic chk(input string rq, input logic e0, input logic e1);
    n_chk++;
    if (gnt0 !== e0 || gnt1 !== e1) begin
      n_bad++;
      $display("FAIL %s: gnt1/gnt0=%b%b expected %b%b", rq, gnt1, gnt0, e1, e0);
    end
    n_chk++;
    if (gnt0 === 1'b1 && gnt1 === 1'b1) begin
      n_bad++;
      $display("FAIL R2: gnt1/gnt0=11 expected at most one high");
    end
  endtask

  // Drive requests at the falling edge, sample 1 ns after the next rising edge.
  task automatic step(input logic r0, input logic r1);
    @(negedge clk);
    req0 = r0;
    req1 = r1;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk("R1 idle after reset", 1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R1 first conflict to 0", 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, i[0]);
      chk("R3 owner 0 holds", 1'b1, 1'b0);
    end
  endtask

  task automatic t_handoff();
    step(1'b0, 1'b1);
    chk("R4 hand-off 0->1", 1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R3 owner 1 holds vs req0", 1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R4 hand-off 1->0", 1'b1, 1'b0);
  endtask

  task automatic t_release_and_turn();
    step(1'b0, 1'b0);
    chk("R5 release 0 to idle", 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    chk("R8 idle stays idle", 1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R6 R8 turn 1 after long idle", 1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 release 1 to idle", 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R6 R8 turn 0 after idle", 1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R5 release 0 again", 1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R6 turn 1 with no idle gap", 1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  task automatic t_single();
    // turn is now 0
    step(1'b0, 1'b1);
    chk("R7 lone req1 against turn", 1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 release 1", 1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R7 lone req0 with turn", 1'b1, 1'b0);
    step(1'b0, 1'b0);
    // turn is now 1
    step(1'b1, 1'b0);
    chk("R7 lone req0 against turn", 1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic t_registered();
    // turn is now 1; change requests away from the edge
    @(negedge clk);
    req0 = 1'b1;
    #1;
    chk("R9 no grant before edge", 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R9 grant at edge", 1'b1, 1'b0);
    @(negedge clk);
    req0 = 1'b0;
    req1 = 1'b1;
    #1;
    chk("R9 hold until edge", 1'b1, 1'b0);
    @(posedge clk);
    #1;
    chk("R4 R9 hand-off at edge", 1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 final release", 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_handoff();
    t_release_and_turn();
    t_single();
    t_registered();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule